// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address for a 16-bit processor core. It keeps four 16-bit segment bases: code, data, extra and stack. On each request it picks one base from the kind of access and adds it, shifted left by four bit positions, to the offset. The sum wraps at the top of the 1 MiB space.

By default, instruction fetches use the code base and pointer-based stack accesses use the stack base. String destinations use the extra base, and all other data accesses use the data base. A segment-override input can redirect general data accesses and base-pointer accesses to any of the four bases. It has no effect on fetches, stack-pointer accesses or string destinations.

The request side is valid/ready and the address side is valid/ready. The path through the block is combinational. The address output is valid in the same cycle as its request. Back-pressure from the consumer (`addr_ready` low) appears at once on `req_ready`. A requester that is held off keeps its request fields steady. The address then stays steady as well, as long as no segment write lands in between.

Segment bases are loaded through a write port. A write takes effect at the next clock edge.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset the code base equals the parameter CODE_RST (default 0xFFFF) and the other three bases are 0. The first fetch at offset 0 therefore yields 0xFFFF0.
- R2: The address equals (base << 4) + zero-extended offset, truncated to 20 bits. It wraps at 1 MiB (base 0xFFFF with offset 0xFFFF gives 0x0FFEF), and its low 4 bits always equal the offset's low 4 bits.
- R3: Access kind 0 (instruction fetch) uses the code base and ignores the override.
- R4: Access kind 1 (stack-pointer access) uses the stack base and ignores the override.
- R5: Access kind 2 (base-pointer access) uses the stack base unless the override is enabled, in which case it uses the override base.
- R6: Access kind 3 (general data), and the unassigned codes 5 to 7, use the data base unless the override is enabled, in which case they use the override base.
- R7: Access kind 4 (string destination) uses the extra base and ignores the override.
- R8: Base selector encoding is 0 code, 1 data, 2 extra, 3 stack. A write is visible from the next clock edge, and a request in the same cycle as the write sees the old base.
- R9: `addr_valid` follows `req_valid` and `req_ready` follows `addr_ready` in the same cycle. While no write occurs and the request fields are steady, `addr_out` stays steady.
- R10: The override selector `ovr_sel` uses the same encoding as the write selector (0 code, 1 data, 2 extra, 3 stack).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment base write enable |
| seg_wsel | input | 2 | Base to write (0 code, 1 data, 2 extra, 3 stack) |
| seg_wdata | input | 16 | New base value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 3 | Access kind (0 fetch, 1 stack ptr, 2 base ptr, 3 data, 4 string dest) |
| req_off | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override base (same encoding as seg_wsel) |
| addr_valid | output | 1 | Address present |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | 20 | Physical address |

## Verification
The bench builds the block with the default parameters: 16-bit bases and offsets, a 4-bit shift and a reset code base of 0xFFFF. With these values, all-ones bases and offsets reach the 1 MiB wrap point, and the reset fetch address 0xFFFF0 can be checked directly. Every access kind is tried with and without the override. One write is paired with a same-cycle request to expose the old-value rule.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = $clog2(NUM_SEG);
  localparam int KIND_W  = 3;

  // base selector encoding, shared by write port and override
  localparam logic [SEL_W-1:0] SEG_CODE  = 2'd0;
  localparam logic [SEL_W-1:0] SEG_DATA  = 2'd1;
  localparam logic [SEL_W-1:0] SEG_EXTRA = 2'd2;
  localparam logic [SEL_W-1:0] SEG_STACK = 2'd3;

  // access kinds
  localparam logic [KIND_W-1:0] KIND_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] KIND_SPTR  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_BPTR  = 3'd2;
  localparam logic [KIND_W-1:0] KIND_DATA  = 3'd3;
  localparam logic [KIND_W-1:0] KIND_SDST  = 3'd4;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter logic [SEG_W-1:0] CODE_RST = '1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [SEL_W-1:0]              wsel,
  input  logic [SEG_W-1:0]              wdata,
  output logic [NUM_SEG-1:0][SEG_W-1:0] bases
);
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_base
    localparam logic [SEG_W-1:0] RST_VAL =
      (SEL_W'(g) == SEG_CODE) ? CODE_RST : '0;
    logic [SEG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                         q <= RST_VAL;
      else if (we && wsel == SEL_W'(g))   q <= wdata;
    end
    assign bases[g] = q;
  end
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              ovr_en,
  input  logic [SEL_W-1:0]  ovr_sel,
  output logic [SEL_W-1:0]  sel
);
  logic [SEL_W-1:0] dflt;
  logic             ovr_ok;

  always_comb begin
    ovr_ok = 1'b0;
    unique case (kind)
      KIND_FETCH: dflt = SEG_CODE;
      KIND_SPTR:  dflt = SEG_STACK;
      KIND_BPTR:  begin dflt = SEG_STACK; ovr_ok = 1'b1; end
      KIND_SDST:  dflt = SEG_EXTRA;
      default:    begin dflt = SEG_DATA;  ovr_ok = 1'b1; end
    endcase
    sel = (ovr_ok && ovr_en) ? ovr_sel : dflt;
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  localparam int MAX_W = (SEG_W + SHIFT > OFF_W) ? SEG_W + SHIFT : OFF_W;
  localparam int SUM_W = ((MAX_W > ADDR_W) ? MAX_W : ADDR_W) + 1;

  logic [SUM_W-1:0] base_w, off_w, sum;

  always_comb begin
    base_w = SUM_W'(base) << SHIFT;
    off_w  = SUM_W'(off);
    sum    = base_w + off_w;
    addr   = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_we,
  input  logic [SEL_W-1:0]   seg_wsel,
  input  logic [SEG_W-1:0]   seg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               ovr_en,
  input  logic [SEL_W-1:0]   ovr_sel,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [ADDR_W-1:0]  addr_out
);
  logic [NUM_SEG-1:0][SEG_W-1:0] bases;
  logic [SEL_W-1:0]              sel;
  logic [SEG_W-1:0]              base_cur;

  seg_regfile #(.SEG_W(SEG_W), .CODE_RST(CODE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(seg_we), .wsel(seg_wsel),
    .wdata(seg_wdata), .bases(bases)
  );

  seg_select u_sel (
    .kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .sel(sel)
  );

  assign base_cur = bases[sel];

  seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
    .base(base_cur), .off(req_off), .addr(addr_out)
  );

  // combinational stream path: back-pressure passes straight through
  assign addr_valid = req_valid;
  assign req_ready  = addr_ready;
endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seg_we,
  input logic [SEL_W-1:0]   seg_wsel,
  input logic [SEG_W-1:0]   seg_wdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic [KIND_W-1:0]  req_kind,
  input logic [OFF_W-1:0]   req_off,
  input logic               ovr_en,
  input logic [SEL_W-1:0]   ovr_sel,
  input logic               addr_valid,
  input logic               addr_ready,
  input logic [ADDR_W-1:0]  addr_out
);
  assert_low_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out[SHIFT-1:0] == req_off[SHIFT-1:0]);

  assert_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid == req_valid) && (req_ready == addr_ready));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(seg_we) && $stable(req_kind) && $stable(req_off)
     && $stable(ovr_en) && $stable(ovr_sel)) |-> $stable(addr_out));

  assert_fetch_ignores_ovr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(seg_we) && req_kind == KIND_FETCH
     && $past(req_kind) == KIND_FETCH && $stable(req_off)) |-> $stable(addr_out));

  assert_code_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(seg_we) && $past(seg_wsel) == SEG_CODE
     && req_kind == KIND_FETCH && req_off == '0)
    |-> addr_out == {$past(seg_wdata), {SHIFT{1'b0}}});
endmodule

bind seg_addr_unit seg_addr_unit_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
  .seg_wdata(seg_wdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_off(req_off), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
  .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out)
);

// File: tb/seg_addr_unit_test.sv
`timescale 1ns/1ps
module seg_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_we = 1'b0;
  logic [1:0]  seg_wsel = '0;
  logic [15:0] seg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_off = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic        addr_valid;
  logic        addr_ready = 1'b1;
  logic [19:0] addr_out;

  always #2 clk = ~clk;

  seg_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
    .seg_wdata(seg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_off(req_off), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out)
  );

  typedef struct {
    logic [19:0] addr;
    logic        vld;
    logic        rdy;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model [4];
  int          applied = 0;
  int          bad = 0;
  bit          done = 0;

  function automatic logic [19:0] exp_addr(logic [2:0] k, logic [15:0] o,
                                           logic oe, logic [1:0] os);
    logic [1:0]  s;
    logic [20:0] w;
    case (k)
      3'd0: s = 2'd0;
      3'd1: s = 2'd3;
      3'd2: s = oe ? os : 2'd3;
      3'd4: s = 2'd2;
      default: s = oe ? os : 2'd1;
    endcase
    w = ({5'd0, model[s]} << 4) + {5'd0, o};
    return w[19:0];
  endfunction

  task automatic step(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                      input logic rv, input logic ar, input logic [2:0] k,
                      input logic [15:0] o, input logic oe, input logic [1:0] os,
                      input string tag);
    exp_t e;
    @(negedge clk);
    seg_we = we; seg_wsel = ws; seg_wdata = wd;
    req_valid = rv; addr_ready = ar; req_kind = k; req_off = o;
    ovr_en = oe; ovr_sel = os;
    e.addr = exp_addr(k, o, oe, os);
    e.vld = rv; e.rdy = ar; e.tag = tag;
    sb.push_back(e);
    if (we) model[ws] = wd;
  endtask

  // monitor: samples 1 ns after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        applied++;
        if (addr_out !== e.addr || addr_valid !== e.vld || req_ready !== e.rdy) begin
          bad++;
          $display("FAIL %s: addr=%05h vld=%0b rdy=%0b expected addr=%05h vld=%0b rdy=%0b",
                   e.tag, addr_out, addr_valid, req_ready, e.addr, e.vld, e.rdy);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    model[0] = 16'hFFFF; model[1] = '0; model[2] = '0; model[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset bases
    step(0, 0, 0, 1, 1, 3'd0, 16'h0000, 0, 0, "R1");
    step(0, 0, 0, 1, 1, 3'd3, 16'h0010, 0, 0, "R1");
    // R8 same-cycle write sees old code base, next cycle new one
    step(1, 2'd0, 16'h1234, 1, 1, 3'd0, 16'h0005, 0, 0, "R8");
    step(0, 0, 0, 1, 1, 3'd0, 16'h0005, 0, 0, "R8");
    // load remaining bases with no request present
    step(1, 2'd1, 16'h2000, 0, 1, 3'd3, 16'h0000, 0, 0, "R9");
    step(1, 2'd3, 16'h3000, 0, 1, 3'd3, 16'h0000, 0, 0, "R9");
    step(1, 2'd2, 16'h4000, 1, 1, 3'd3, 16'h0000, 0, 0, "R8");
    // R6 data default, unassigned code, override
    step(0, 0, 0, 1, 1, 3'd3, 16'h0ABC, 0, 0, "R6");
    step(0, 0, 0, 1, 1, 3'd5, 16'h0001, 0, 0, "R6");
    step(0, 0, 0, 1, 1, 3'd7, 16'h0002, 1, 2'd3, "R6");
    step(0, 0, 0, 1, 1, 3'd3, 16'h0010, 1, 2'd2, "R10");
    // R4 stack pointer, override ignored
    step(0, 0, 0, 1, 1, 3'd1, 16'hFFFE, 0, 0, "R4");
    step(0, 0, 0, 1, 1, 3'd1, 16'hFFFE, 1, 2'd0, "R4");
    // R5 base pointer, default and overridden
    step(0, 0, 0, 1, 1, 3'd2, 16'h0020, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 3'd2, 16'h0020, 1, 2'd1, "R5");
    // R7 string destination, override ignored
    step(0, 0, 0, 1, 1, 3'd4, 16'h0007, 0, 0, "R7");
    step(0, 0, 0, 1, 1, 3'd4, 16'h0007, 1, 2'd3, "R7");
    // R3 fetch, override ignored
    step(0, 0, 0, 1, 1, 3'd0, 16'h0010, 1, 2'd1, "R3");
    step(0, 0, 0, 1, 1, 3'd0, 16'h0010, 1, 2'd3, "R3");
    // R2 wrap at 1 MiB and carry across nibble boundary
    step(1, 2'd1, 16'hFFFF, 1, 1, 3'd3, 16'h0008, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 3'd3, 16'hFFFF, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 3'd3, 16'h001F, 0, 0, "R2");
    // R9 back-pressure and hold
    step(0, 0, 0, 1, 0, 3'd2, 16'h1111, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 3'd2, 16'h1111, 0, 0, "R9");
    step(0, 0, 0, 1, 1, 3'd2, 16'h1111, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 3'd0, 16'h0000, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule